// File: doc/BRIEF.md
# Cascaded Interrupt Controller

This block collects interrupt requests from a chain of controllers and raises a single interrupt request to the processor. The chain has one primary controller and `NSEC` secondary controllers. `NSEC` ranges from 1 to 3 and defaults to 3. Each controller holds 32 request bits and three registers:

- a sticky status register that latches the request inputs;
- an enable register that gates the status bits;
- a steering register that marks each bit as critical or non-critical.

Software reads the gated result through a read-only masked view. It acknowledges requests by writing ones to the status register.

Each secondary folds into the primary through two of the primary's status bits. One bit carries the secondary's critical summary and the other carries its non-critical summary. The processor handler then reads the primary's masked view. From it, the handler can tell whether a secondary needs attention, and whether that attention is urgent.

Bit order in every register is most-significant-first: register bit 31 is local vector 0 and register bit 0 is local vector 31. The global vector ranges are:

| Controller | Global vectors |
|---|---|
| Primary | 0 to 31 |
| Secondary k | 32k to 32k+31 |

Every controller is reached through one shared register port. The port has an address, write data, a write strobe and combinational read data. It carries no streaming data, so it has no valid/ready handshake: a write takes effect on the clock edge where the strobe is high, and it is never stalled.

Top module: `uic_cascade`

## Requirements
- R1: After reset, every status, enable and steering register of every controller reads zero, and `cpu_irq_o` is low.
- R2: A status bit is set on every clock edge at which its request input is high, and it stays set after the input falls until software clears it.
- R3: A write to the status register (register code 0) clears each status bit whose write-data bit is 1 and leaves every other bit unchanged.
- R4: When a request is high on the same edge as a clear of its status bit, the set wins and the bit stays 1.
- R5: The masked view (register code 2) reads as status AND enable. Writes to the masked view change no register.
- R6: The enable register (code 1) can be read and written. `cpu_irq_o` is high exactly while the primary's status AND enable is non-zero. Clearing an enable bit drops the request but leaves the status bit intact.
- R7: External input `prim_irq_i[j]` drives primary status bit j+2·NSEC. Input `sec_irq_i[32(k-1)+b]` drives status bit b of secondary k, which is global vector 32k+31-b.
- R8: Secondary k produces a critical summary, the OR of its masked bits whose steering bit is 1, and a non-critical summary, the OR of its other masked bits. These summaries drive primary status bits 2k-1 and 2k-2 respectively. Each summary is latched there on the edge after it first appears in the secondary's masked view.
- R9: The address is {instance, register}. The low two bits select the register: 0 status, 1 enable, 2 masked, 3 steering. The upper bits select the instance: 0 is the primary and k is secondary k. Read data is combinational from the address. An instance number above NSEC reads zero.
- R10: The steering register (code 3) can be read and written. It only chooses which summary a masked bit feeds and has no effect on status or enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prim_irq_i | input | 32-2·NSEC | External requests into the primary's free bits |
| sec_irq_i | input | 32·NSEC | Requests into the secondaries, 32 bits each |
| bus_addr_i | input | clog2(NSEC+1)+2 | Register address {instance, register} |
| bus_we_i | input | 1 | Write strobe |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Combinational read data |
| cpu_irq_o | output | 1 | Interrupt request to the processor |

## Verification
Any wrong bit in a status, enable or steering register shows at the port one of two ways. It is either visible on the read port in the same cycle the register is addressed, or, for the primary, it shows on `cpu_irq_o` in the cycle after the bad update. A wrong bit in a secondary appears in the primary's status one edge later, as a wrong summary bit. That extra edge is why the cascade checks sample the primary's status twice: once right after the enable edge, when it must still read zero, and once an edge later. A swapped summary pair or a bit-order error shows as the wrong primary bit, so those checks compare whole words rather than single flags.

// File: rtl/uic_pkg.sv
package uic_pkg;
  localparam int unsigned UIC_W = 32;

  typedef enum logic [1:0] {
    UR_STAT = 2'd0,
    UR_ENAB = 2'd1,
    UR_MASK = 2'd2,
    UR_CSEL = 2'd3
  } uic_reg_e;
endpackage

// File: rtl/uic_addr_dec.sv
module uic_addr_dec
  import uic_pkg::*;
#(
  parameter int unsigned NINST = 4,
  parameter int unsigned IDX_W = $clog2(NINST)
) (
  input  logic [IDX_W+1:0] addr_i,
  output logic [NINST-1:0] sel_o,
  output uic_reg_e         reg_o
);
  always_comb begin
    reg_o = uic_reg_e'(addr_i[1:0]);
    for (int i = 0; i < NINST; i++) begin
      sel_o[i] = (addr_i[IDX_W+1:2] == IDX_W'(i));
    end
  end

  // R9: at most one instance selected
  always_comb begin
    a_r9_one_select: assert ($onehot0(sel_o));
  end
endmodule

// File: rtl/uic_node.sv
module uic_node
  import uic_pkg::*;
#(
  parameter int unsigned W = UIC_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] req_i,
  input  logic         sel_i,
  input  uic_reg_e     reg_i,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] rdata_o,
  output logic         crit_o,
  output logic         ncrit_o
);
  logic [W-1:0] status_q, enable_q, csel_q;
  logic [W-1:0] masked, clr_mask;
  logic         wr_en, wr_csel;

  assign wr_en   = sel_i && we_i && (reg_i == UR_ENAB);
  assign wr_csel = sel_i && we_i && (reg_i == UR_CSEL);
  assign clr_mask = (sel_i && we_i && (reg_i == UR_STAT)) ? wdata_i : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      enable_q <= '0;
      csel_q   <= '0;
    end else begin
      status_q <= (status_q & ~clr_mask) | req_i;
      if (wr_en)   enable_q <= wdata_i;
      if (wr_csel) csel_q   <= wdata_i;
    end
  end

  assign masked  = status_q & enable_q;
  assign crit_o  = |(masked & csel_q);
  assign ncrit_o = |(masked & ~csel_q);

  always_comb begin
    rdata_o = '0;
    if (sel_i) begin
      case (reg_i)
        UR_STAT: rdata_o = status_q;
        UR_ENAB: rdata_o = enable_q;
        UR_MASK: rdata_o = masked;
        UR_CSEL: rdata_o = csel_q;
        default: rdata_o = '0;
      endcase
    end
  end

  // R2: a newly set bit must come from a request
  a_r2_set_from_req: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_q & ~$past(status_q) & ~$past(req_i)) == '0));
  // R3: a cleared bit without a request is zero afterwards
  a_r3_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_q & $past(clr_mask & ~req_i)) == '0));
  // R4: a request always wins
  a_r4_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_q & $past(req_i)) == $past(req_i)));
  // R5: masked view writes leave enable unchanged
  a_r5_mask_ro: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i && we_i && reg_i == UR_MASK) |=> $stable(enable_q) && $stable(csel_q));
  // R8: the two summaries never exceed masked activity
  a_r8_summary_split: assert property (@(posedge clk) disable iff (!rst_n)
    (crit_o || ncrit_o) |-> (masked != '0));
endmodule

// File: rtl/uic_cascade.sv
module uic_cascade
  import uic_pkg::*;
#(
  parameter int unsigned NSEC     = 3,
  parameter int unsigned NINST    = NSEC + 1,
  parameter int unsigned IDX_W    = $clog2(NINST),
  parameter int unsigned ADDR_W   = IDX_W + 2,
  parameter int unsigned PRIM_EXT = UIC_W - 2 * NSEC
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [PRIM_EXT-1:0]    prim_irq_i,
  input  logic [NSEC*UIC_W-1:0]  sec_irq_i,
  input  logic [ADDR_W-1:0]      bus_addr_i,
  input  logic                   bus_we_i,
  input  logic [UIC_W-1:0]       bus_wdata_i,
  output logic [UIC_W-1:0]       bus_rdata_o,
  output logic                   cpu_irq_o
);
  logic [NINST-1:0] sel;
  uic_reg_e         reg_sel;
  logic [UIC_W-1:0] rd [NINST];
  logic [NSEC-1:0]  sec_crit, sec_ncrit;
  logic [2*NSEC-1:0] cas;
  logic             p_crit, p_ncrit;

  uic_addr_dec #(.NINST(NINST), .IDX_W(IDX_W)) u_dec (
    .addr_i(bus_addr_i), .sel_o(sel), .reg_o(reg_sel)
  );

  uic_node #(.W(UIC_W)) u_prim (
    .clk(clk), .rst_n(rst_n), .req_i({prim_irq_i, cas}),
    .sel_i(sel[0]), .reg_i(reg_sel), .we_i(bus_we_i), .wdata_i(bus_wdata_i),
    .rdata_o(rd[0]), .crit_o(p_crit), .ncrit_o(p_ncrit)
  );

  assign cpu_irq_o = p_crit | p_ncrit;

  for (genvar k = 0; k < NSEC; k++) begin : g_sec
    uic_node #(.W(UIC_W)) u_sec (
      .clk(clk), .rst_n(rst_n), .req_i(sec_irq_i[k*UIC_W +: UIC_W]),
      .sel_i(sel[k+1]), .reg_i(reg_sel), .we_i(bus_we_i), .wdata_i(bus_wdata_i),
      .rdata_o(rd[k+1]), .crit_o(sec_crit[k]), .ncrit_o(sec_ncrit[k])
    );
    assign cas[2*k+1] = sec_crit[k];
    assign cas[2*k]   = sec_ncrit[k];

    // R8: summaries land in the primary on the next edge
    a_r8_crit_lands: assert property (@(posedge clk) disable iff (!rst_n)
      sec_crit[k] |=> u_prim.status_q[2*k+1]);
    a_r8_ncrit_lands: assert property (@(posedge clk) disable iff (!rst_n)
      sec_ncrit[k] |=> u_prim.status_q[2*k]);
  end

  always_comb begin
    bus_rdata_o = '0;
    for (int i = 0; i < NINST; i++) bus_rdata_o |= rd[i];
  end

  // R6: processor request drops with an empty primary status
  a_r6_irq_needs_status: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq_o |-> (u_prim.status_q != '0));
endmodule

// File: tb/sim_uic_cascade.sv
`timescale 1ns/100ps
module sim_uic_cascade;
  localparam int NSEC = 3;
  localparam int PE = 32 - 2 * NSEC;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [PE-1:0] prim_irq_i = '0;
  logic [NSEC*32-1:0] sec_irq_i = '0;
  logic [3:0] bus_addr_i = '0;
  logic bus_we_i = 1'b0;
  logic [31:0] bus_wdata_i = '0;
  logic [31:0] bus_rdata_o;
  logic cpu_irq_o;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  uic_cascade #(.NSEC(NSEC)) u0 (
    .clk(clk), .rst_n(rst_n), .prim_irq_i(prim_irq_i), .sec_irq_i(sec_irq_i),
    .bus_addr_i(bus_addr_i), .bus_we_i(bus_we_i), .bus_wdata_i(bus_wdata_i),
    .bus_rdata_o(bus_rdata_o), .cpu_irq_o(cpu_irq_o)
  );

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_addr_i = a; bus_wdata_i = d; bus_we_i = 1'b1;
    tick();
    bus_we_i = 1'b0;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic rdchk(input string tag, input logic [3:0] a, input logic [31:0] exp);
    bus_addr_i = a; #0.4;
    chk(tag, bus_rdata_o, exp);
  endtask

  task automatic t_reset();
    for (int i = 0; i < 16; i++) rdchk("R1 reset reg", 4'(i), 32'h0);
    chk("R1 reset irq", {31'b0, cpu_irq_o}, 32'h0);
  endtask

  task automatic t_latch();
    prim_irq_i[0] = 1'b1; prim_irq_i[PE-1] = 1'b1;
    tick();
    prim_irq_i = '0;
    tick();
    rdchk("R2 R7 primary latch", 4'd0, 32'h8000_0040);
    chk("R6 irq off while disabled", {31'b0, cpu_irq_o}, 32'h0);
  endtask

  task automatic t_w1c_mask();
    wr(4'd0, 32'h0000_0041);
    rdchk("R3 w1c partial", 4'd0, 32'h8000_0000);
    wr(4'd2, 32'hFFFF_FFFF);
    rdchk("R5 masked write ignored status", 4'd0, 32'h8000_0000);
    rdchk("R5 masked write ignored enable", 4'd1, 32'h0);
    wr(4'd1, 32'h8000_0001);
    rdchk("R6 enable readback", 4'd1, 32'h8000_0001);
    rdchk("R5 masked and", 4'd2, 32'h8000_0000);
    chk("R6 irq on", {31'b0, cpu_irq_o}, 32'h1);
    wr(4'd1, 32'h0);
    chk("R6 irq off after disable", {31'b0, cpu_irq_o}, 32'h0);
    rdchk("R6 status kept", 4'd0, 32'h8000_0000);
    wr(4'd0, 32'hFFFF_FFFF);
    rdchk("R3 w1c all", 4'd0, 32'h0);
  endtask

  task automatic t_set_prio();
    prim_irq_i[1] = 1'b1;
    wr(4'd0, 32'h0000_0080);
    rdchk("R4 set over clear", 4'd0, 32'h0000_0080);
    prim_irq_i = '0;
    wr(4'd0, 32'h0000_0080);
    rdchk("R3 clear after drop", 4'd0, 32'h0);
  endtask

  task automatic t_csel();
    wr(4'd11, 32'hA5A5_0000);
    rdchk("R10 steer readback", 4'd11, 32'hA5A5_0000);
    rdchk("R10 no status effect", 4'd8, 32'h0);
    wr(4'd11, 32'h0);
  endtask

  task automatic t_cascade();
    sec_irq_i[32+5] = 1'b1;
    tick();
    sec_irq_i = '0;
    rdchk("R7 secondary latch", 4'd8, 32'h0000_0020);
    wr(4'd9, 32'h0000_0020);
    rdchk("R8 not yet in primary", 4'd0, 32'h0);
    tick();
    rdchk("R8 noncrit in primary", 4'd0, 32'h0000_0004);
    wr(4'd11, 32'h0000_0020);
    tick();
    rdchk("R8 crit in primary", 4'd0, 32'h0000_000C);
    wr(4'd0, 32'h0000_0004);
    rdchk("R3 cleared idle summary", 4'd0, 32'h0000_0008);
    wr(4'd0, 32'h0000_0008);
    rdchk("R4 live summary survives clear", 4'd0, 32'h0000_0008);
    wr(4'd1, 32'h0000_0008);
    chk("R6 irq from cascade", {31'b0, cpu_irq_o}, 32'h1);
    wr(4'd8, 32'h0000_0020);
    wr(4'd0, 32'h0000_0008);
    rdchk("R8 cascade released", 4'd0, 32'h0);
    chk("R6 irq released", {31'b0, cpu_irq_o}, 32'h0);
    wr(4'd9, 32'h0); wr(4'd11, 32'h0); wr(4'd1, 32'h0);
  endtask

  task automatic t_multi();
    sec_irq_i[0] = 1'b1; sec_irq_i[64+31] = 1'b1;
    tick();
    sec_irq_i = '0;
    wr(4'd7, 32'h0000_0001);
    wr(4'd5, 32'h0000_0001);
    wr(4'd13, 32'h8000_0000);
    tick();
    rdchk("R8 R7 sec1 crit and sec3 noncrit", 4'd0, 32'h0000_0012);
    rdchk("R7 sec3 vector 96 bit", 4'd12, 32'h8000_0000);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    tick();
    t_reset();
    t_latch();
    t_w1c_mask();
    t_set_prio();
    t_csel();
    t_cascade();
    t_multi();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule